// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block collects a set of external interrupt lines and turns each one into an interrupt message. A message carries an 8-bit vector, an 8-bit destination ID, a destination-mode flag and a trigger-mode flag. Software programs the block through a small memory-mapped window with three byte offsets. A selector register at offset 0x00 picks an internal register. A 32-bit data port at offset 0x10 reads or writes the register that the selector picks. An acknowledge port at offset 0x40 takes a vector number and retires level-triggered sources.

The internal space holds an identity word at index 0x00 and a version word at index 0x01. A table of 64-bit redirection entries follows, one entry per input line. Entry n uses index 0x10+2n for its low word and 0x10+2n+1 for its high word. Each line is synchronized through two flops and its polarity is applied. The line is then treated as edge- or level-triggered according to its entry. Pending lines compete for a single message output with a valid/ready handshake, and the lowest entry index wins.

Top module: `irq_redir_ctrl`

## Requirements
- R1: After reset the selector reads 0, no message is valid, every entry's low word reads 0x00010000 (masked, vector 0) and every high word reads 0.
- R2: A write at offset 0x00 loads the selector from bits 7:0. Reading offset 0x00 returns the selector, and reading offset 0x10 returns the register it selects. A low word reads back the vector in bits 7:0, logical destination in bit 11, active-low polarity in bit 13, level trigger in bit 15 and mask in bit 16. A high word reads back the destination in bits 31:24. All other bits read 0, and so do indices outside the identity, version and table ranges.
- R3: Index 0x00 holds a writable 4-bit controller ID in bits 27:24. Index 0x01 reads the version (0x20) in bits 7:0 and the entry count minus one (23) in bits 23:16.
- R4: Writes to indices 0x01 and 0x02 have no effect, and index 0x02 reads 0.
- R5: An edge-triggered, unmasked line produces exactly one message for each inactive-to-active transition, with polarity applied (bit 13 set makes a low input active). A line held active produces no further message.
- R6: When a message from a level-triggered line is accepted, the entry's read-only in-service flag (low-word bit 14) is set. While that flag is set, the line sends no message.
- R7: A write of a vector to offset 0x40 clears the in-service flag of every level entry whose vector matches. A vector that does not match changes nothing, and a still-active line is then sent again.
- R8: A masked entry never starts a message. An edge that arrives while the entry is masked is dropped and is not sent when the entry is unmasked.
- R9: When several lines request at once, the lowest entry index is sent first.
- R10: While the message is valid and ready is low, the vector, destination, destination mode and trigger mode hold stable and valid stays high.
- R11: Low-word bit 12 reads 1 while the line has an unsent request. For an edge entry this is a captured edge. For a level entry this is an active input with the in-service flag clear, masked or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 24 | Raw interrupt lines, one per entry |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset: 0x00 selector, 0x10 data port, 0x40 acknowledge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message taken when high with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination ID |
| msg_logical | output | 1 | Destination is logical |
| msg_level | output | 1 | Source is level-triggered |

## Verification
The assertions assume that software does not change an entry's trigger mode in the same cycle that the entry's message is accepted or acknowledged. They also assume that a message already launched is not reconfigured while it waits for ready. The properties on the in-service flag and on message stability rely on these two points. The stimulus reprograms an entry only while its line is idle and no message is held. It keeps every input pulse longer than the two-flop synchronizer. Before it selects active-low polarity, it drives the line to its inactive level, so that the polarity change does not create an edge.

// File: rtl/irc_pkg.sv
// Shared types and constants for the interrupt redirection controller.
// Assumes an 8-bit internal index space and byte offsets below 128.
package irc_pkg;

    // One redirection entry as held in the table
    typedef struct packed {
        logic       mask;
        logic       level;
        logic       active_low;
        logic       logical;
        logic [7:0] vector;
        logic [7:0] dest;
    } rte_t;

    // Byte offsets of the software-visible ports
    localparam logic [6:0] OFS_SELECT = 7'h00;
    localparam logic [6:0] OFS_WINDOW = 7'h10;
    localparam logic [6:0] OFS_ACK    = 7'h40;

    // Internal indices
    localparam logic [7:0] IDX_IDENT  = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] IDX_ARB    = 8'h02;
    localparam logic [7:0] IDX_TABLE  = 8'h10;

    // Entry value after reset: masked, vector 0, destination 0
    localparam rte_t RTE_RESET = '{mask: 1'b1, level: 1'b0, active_low: 1'b0,
                                   logical: 1'b0, vector: 8'h00, dest: 8'h00};

endpackage

// File: rtl/irc_regs.sv
// Register file: selector, identity, version and the redirection table,
// reached through a selector/data window. Assumes N_LINES <= 120 so the
// table fits in the 8-bit index space. Reads are combinational.
module irc_regs
    import irc_pkg::*;
#(
    parameter int         N_LINES  = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    parameter logic [3:0] ID_RESET = 4'h0,
    localparam int        ENT_W    = $clog2(N_LINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [6:0]              bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [N_LINES-1:0]      status_i,
    input  logic [N_LINES-1:0]      irr_i,
    output rte_t [N_LINES-1:0]      cfg_o,
    output logic                    ack_valid_o,
    output logic [7:0]              ack_vec_o
);
    localparam logic [7:0] MAXENT    = 8'(N_LINES - 1);
    localparam logic [8:0] TABLE_END = 9'(IDX_TABLE) + 9'(2 * N_LINES);

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    rte_t             tbl_q [N_LINES];
    logic [7:0]       rel;
    logic [ENT_W-1:0] ent_sel;
    logic             in_table;
    logic             is_hi;
    logic             win_wr;
    logic [31:0]      win_data;
    logic             unused_bits;

    assign rel      = sel_q - IDX_TABLE;
    assign ent_sel  = rel[ENT_W:1];
    assign is_hi    = rel[0];
    assign in_table = (sel_q >= IDX_TABLE) && ({1'b0, sel_q} < TABLE_END);
    assign win_wr   = bus_wr && (bus_addr == OFS_WINDOW);
    assign unused_bits = ^{bus_wdata, rel};

    // Acknowledge port: a write presents its vector to every line for one cycle
    assign ack_valid_o = bus_wr && (bus_addr == OFS_ACK);
    assign ack_vec_o   = bus_wdata[7:0];

    // Selector register
    always_ff @(posedge clk) begin
        if (!rst_n)                                  sel_q <= 8'h00;
        else if (bus_wr && bus_addr == OFS_SELECT)   sel_q <= bus_wdata[7:0];
    end

    // Controller ID; indices 0x01 and 0x02 take no writes
    always_ff @(posedge clk) begin
        if (!rst_n)                          id_q <= ID_RESET;
        else if (win_wr && sel_q == IDX_IDENT) id_q <= bus_wdata[27:24];
    end

    // One write port per table entry
    for (genvar i = 0; i < N_LINES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_q[i] <= RTE_RESET;
            end else if (win_wr && in_table && ent_sel == ENT_W'(i)) begin
                if (is_hi) begin
                    tbl_q[i].dest <= bus_wdata[31:24];
                end else begin
                    tbl_q[i].vector     <= bus_wdata[7:0];
                    tbl_q[i].logical    <= bus_wdata[11];
                    tbl_q[i].active_low <= bus_wdata[13];
                    tbl_q[i].level      <= bus_wdata[15];
                    tbl_q[i].mask       <= bus_wdata[16];
                end
            end
        end
        assign cfg_o[i] = tbl_q[i];
    end

    // Data-window read mux for the selected internal register
    always_comb begin
        win_data = 32'h0;
        if (sel_q == IDX_IDENT) begin
            win_data = {4'h0, id_q, 24'h0};
        end else if (sel_q == IDX_VER) begin
            win_data = {8'h00, MAXENT, 8'h00, VERSION};
        end else if (in_table) begin
            if (is_hi)
                win_data = {tbl_q[ent_sel].dest, 24'h0};
            else
                win_data = {15'h0, tbl_q[ent_sel].mask, tbl_q[ent_sel].level,
                            irr_i[ent_sel], tbl_q[ent_sel].active_low,
                            status_i[ent_sel], tbl_q[ent_sel].logical, 3'h0,
                            tbl_q[ent_sel].vector};
        end
    end

    // Byte-offset read mux
    always_comb begin
        case (bus_addr)
            OFS_SELECT: bus_rdata = {24'h0, sel_q};
            OFS_WINDOW: bus_rdata = win_data;
            default:    bus_rdata = 32'h0;
        endcase
    end

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == OFS_SELECT |=> sel_q == $past(bus_wdata[7:0]));

    // R4
    ro_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr && (sel_q == IDX_ARB || sel_q == IDX_VER) |=> $stable(id_q));

endmodule

// File: rtl/irc_line.sv
// Input conditioning for one line: two-flop synchronizer, polarity,
// edge capture and the in-service flag of level entries. Assumes the
// trigger mode is not changed while a message from this line is in flight.
module irc_line (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_i,
    input  logic       mask_i,
    input  logic       level_i,
    input  logic       active_low_i,
    input  logic [7:0] vector_i,
    input  logic       accept_i,
    input  logic       ack_valid_i,
    input  logic [7:0] ack_vec_i,
    output logic       req_o,
    output logic       status_o,
    output logic       irr_o
);
    logic sync1_q, sync2_q;
    logic prev_q;
    logic pend_q;
    logic irr_q;
    logic active;
    logic rise;
    logic ack_hit;

    assign active  = sync2_q ^ active_low_i;
    assign rise    = active && !prev_q;
    assign ack_hit = ack_valid_i && (ack_vec_i == vector_i);

    // Two-flop synchronizer of the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
        end
    end

    // Previous active state for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= active;
    end

    // Captured edge: set by an unmasked rise, cleared on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n || level_i) pend_q <= 1'b0;
        else                   pend_q <= (pend_q && !accept_i) || (rise && !mask_i);
    end

    // In-service flag of level entries: set on acceptance, cleared by matching ack
    always_ff @(posedge clk) begin
        if (!rst_n || !level_i) irr_q <= 1'b0;
        else if (accept_i)      irr_q <= 1'b1;
        else if (ack_hit)       irr_q <= 1'b0;
    end

    assign status_o = level_i ? (active && !irr_q) : pend_q;
    assign req_o    = status_o && !mask_i;
    assign irr_o    = irr_q;

    // R6
    irr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_i && level_i |=> irr_q || !level_i);

    // R7
    irr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irr_q && level_i && !ack_hit && !accept_i |=> irr_q || !level_i);

    // R6
    irr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irr_q && level_i |-> !req_o);

endmodule

// File: rtl/irc_arbiter.sv
// Picks the lowest-index requesting line, latches its message and holds
// it under valid until ready. After each acceptance it idles one cycle so
// the accepted line's state has settled before the next pick.
module irc_arbiter
    import irc_pkg::*;
#(
    parameter int  N_LINES = 24,
    localparam int IDX_W   = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINES-1:0]   req_i,
    input  rte_t [N_LINES-1:0]   cfg_i,
    output logic                 launch_o,
    output logic [IDX_W-1:0]     pick_o,
    output logic [N_LINES-1:0]   accept_o,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [7:0]           msg_vector,
    output logic [7:0]           msg_dest,
    output logic                 msg_logical,
    output logic                 msg_level
);
    logic             valid_q;
    logic [IDX_W-1:0] held_q;
    logic [IDX_W-1:0] pick;
    logic             found;
    logic             take;
    logic [N_LINES-1:0] below;

    // Lowest-index requester
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (req_i[i] && !found) begin
                pick  = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    assign take     = valid_q && msg_ready;
    assign launch_o = !valid_q && found;
    assign pick_o   = pick;
    assign below    = ~({N_LINES{1'b1}} << pick);

    // Message holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q     <= 1'b0;
            held_q      <= '0;
            msg_vector  <= 8'h00;
            msg_dest    <= 8'h00;
            msg_logical <= 1'b0;
            msg_level   <= 1'b0;
        end else if (take) begin
            valid_q <= 1'b0;
        end else if (launch_o) begin
            valid_q     <= 1'b1;
            held_q      <= pick;
            msg_vector  <= cfg_i[pick].vector;
            msg_dest    <= cfg_i[pick].dest;
            msg_logical <= cfg_i[pick].logical;
            msg_level   <= cfg_i[pick].level;
        end
    end

    // One-hot acceptance back to the owning line
    always_comb begin
        accept_o = '0;
        if (take) accept_o[held_q] = 1'b1;
    end

    assign msg_valid = valid_q;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
        $stable(msg_dest) && $stable(msg_logical) && $stable(msg_level));

    // R9
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |-> (req_i & below) == '0);

    // R10
    accept_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(accept_o));

endmodule

// File: rtl/irq_redir_ctrl.sv
// Top of the interrupt redirection controller: register file, one
// conditioning slice per line and the message arbiter. Assumes msg_ready
// is only meaningful while msg_valid is high.
module irq_redir_ctrl
    import irc_pkg::*;
#(
    parameter int         N_LINES  = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    parameter logic [3:0] ID_RESET = 4'h0,
    localparam int        IDX_W    = $clog2(N_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_LINES-1:0]  irq_in,
    input  logic                bus_wr,
    input  logic [6:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [7:0]          msg_dest,
    output logic                msg_logical,
    output logic                msg_level
);
    rte_t [N_LINES-1:0] cfg;
    logic [N_LINES-1:0] req;
    logic [N_LINES-1:0] status;
    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] accept;
    logic               ack_valid;
    logic [7:0]         ack_vec;
    logic               launch;
    logic [IDX_W-1:0]   pick;

    irc_regs #(.N_LINES(N_LINES), .VERSION(VERSION), .ID_RESET(ID_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status_i(status), .irr_i(irr), .cfg_o(cfg),
        .ack_valid_o(ack_valid), .ack_vec_o(ack_vec)
    );

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        irc_line u_line (
            .clk(clk), .rst_n(rst_n), .raw_i(irq_in[i]),
            .mask_i(cfg[i].mask), .level_i(cfg[i].level),
            .active_low_i(cfg[i].active_low), .vector_i(cfg[i].vector),
            .accept_i(accept[i]), .ack_valid_i(ack_valid), .ack_vec_i(ack_vec),
            .req_o(req[i]), .status_o(status[i]), .irr_o(irr[i])
        );
    end

    irc_arbiter #(.N_LINES(N_LINES)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(req), .cfg_i(cfg),
        .launch_o(launch), .pick_o(pick), .accept_o(accept),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_level(msg_level)
    );

    // R8
    mask_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !cfg[pick].mask);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !msg_valid);

endmodule

// File: tb/tb_irq_redir_ctrl.sv
module tb_irq_redir_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector, msg_dest;
    logic        msg_logical, msg_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_redir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_level(msg_level)
    );

    // {requirement, index, write data, expected readback}
    localparam logic [79:0] VEC [12] = '{
        {8'd4, 8'h01, 32'hFFFFFFFF, 32'h00170020},
        {8'd4, 8'h02, 32'hFFFFFFFF, 32'h00000000},
        {8'd3, 8'h00, 32'hFFFFFFFF, 32'h0F000000},
        {8'd3, 8'h00, 32'h05000000, 32'h05000000},
        {8'd2, 8'h10, 32'hFFFFDFFF, 32'h000188FF},
        {8'd2, 8'h11, 32'hFFFFFFFF, 32'hFF000000},
        {8'd2, 8'h10, 32'h00010000, 32'h00010000},
        {8'd2, 8'h11, 32'h00000000, 32'h00000000},
        {8'd2, 8'h3F, 32'hAB001234, 32'hAB000000},
        {8'd2, 8'h3F, 32'h00000000, 32'h00000000},
        {8'd2, 8'h40, 32'hFFFFFFFF, 32'h00000000},
        {8'd2, 8'h05, 32'hFFFFFFFF, 32'h00000000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_idx(input logic [7:0] idx, output logic [31:0] v);
        bwrite(7'h00, {24'h0, idx});
        bus_addr = 7'h10;
        #1 v = bus_rdata;
    endtask

    task automatic wr_idx(input logic [7:0] idx, input logic [31:0] d);
        bwrite(7'h00, {24'h0, idx});
        bwrite(7'h10, d);
    endtask

    task automatic wait_msg(input int maxc, output bit got);
        got = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (msg_valid) begin got = 1; break; end
        end
    endtask

    task automatic take_msg();
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        chk(tag, seen, 0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 msg_valid", {31'h0, msg_valid}, 0);
        bus_addr = 7'h00; #1 chk("R1 selector", bus_rdata, 0);
        rd_idx(8'h10, v); chk("R1 entry0 low", v, 32'h00010000);
        rd_idx(8'h3E, v); chk("R1 entry23 low", v, 32'h00010000);
        rd_idx(8'h3F, v); chk("R1 entry23 high", v, 0);

        // R2 R3 R4 register table
        foreach (VEC[k]) begin
            wr_idx(VEC[k][71:64], VEC[k][63:32]);
            rd_idx(VEC[k][71:64], v);
            chk($sformatf("R%0d table row %0d", VEC[k][79:72], k), v, VEC[k][31:0]);
        end
        bus_addr = 7'h00; #1 chk("R2 selector readback", bus_rdata, 32'h05);

        // R5 edge, active high
        wr_idx(8'h17, 32'h05000000);
        wr_idx(8'h16, 32'h00000033);
        irq_in[3] = 1'b1;
        wait_msg(8, got);
        chk("R5 edge msg", {got, msg_vector, msg_dest, msg_level, msg_logical},
            {1'b1, 8'h33, 8'h05, 1'b0, 1'b0});
        take_msg();
        quiet("R5 held line no repeat", 10);
        irq_in[3] = 1'b0; repeat (4) @(negedge clk);
        irq_in[3] = 1'b1;
        wait_msg(8, got);
        chk("R5 second edge", {got, msg_vector}, {1'b1, 8'h33});
        take_msg();

        // R5 edge, active low
        irq_in[4] = 1'b1; repeat (3) @(negedge clk);
        wr_idx(8'h18, 32'h00002044);
        quiet("R5 active-low idle", 6);
        irq_in[4] = 1'b0;
        wait_msg(8, got);
        chk("R5 active-low msg", {got, msg_vector}, {1'b1, 8'h44});
        take_msg();

        // R6 R7 level, logical
        wr_idx(8'h1D, 32'h07000000);
        wr_idx(8'h1C, 32'h00008866);
        irq_in[6] = 1'b1;
        wait_msg(8, got);
        chk("R6 level msg", {got, msg_vector, msg_dest, msg_level, msg_logical},
            {1'b1, 8'h66, 8'h07, 1'b1, 1'b1});
        take_msg();
        rd_idx(8'h1C, v); chk("R6 in-service bit14", v, 32'h0000C866);
        quiet("R6 blocked while in service", 10);
        bwrite(7'h40, 32'h67);
        quiet("R7 wrong vector ack", 8);
        rd_idx(8'h1C, v); chk("R7 flag kept", v, 32'h0000C866);
        bwrite(7'h40, 32'h66);
        wait_msg(8, got);
        chk("R7 resend after ack", {got, msg_vector}, {1'b1, 8'h66});
        take_msg();
        irq_in[6] = 1'b0; repeat (3) @(negedge clk);
        bwrite(7'h40, 32'h66);
        rd_idx(8'h1C, v); chk("R7 cleared idle", v, 32'h00008866);
        quiet("R7 idle no msg", 6);

        // R8 R11 masked level and masked edge
        wr_idx(8'h20, 32'h00018088);
        irq_in[8] = 1'b1;
        quiet("R8 masked level", 10);
        rd_idx(8'h20, v); chk("R11 status bit12 masked level", v, 32'h00019088);
        irq_in[8] = 1'b0;
        wr_idx(8'h22, 32'h00010099);
        irq_in[9] = 1'b1;
        repeat (5) @(negedge clk);
        rd_idx(8'h22, v); chk("R11 masked edge not captured", v, 32'h00010099);
        wr_idx(8'h22, 32'h00000099);
        quiet("R8 dropped edge after unmask", 10);
        irq_in[9] = 1'b0;

        // R9 R10 simultaneous requests
        wr_idx(8'h25, 32'h01000000);
        wr_idx(8'h24, 32'h000000AA);
        wr_idx(8'h29, 32'h02000000);
        wr_idx(8'h28, 32'h000000CC);
        irq_in[10] = 1'b1; irq_in[12] = 1'b1;
        wait_msg(8, got);
        chk("R9 lowest first", {got, msg_vector, msg_dest}, {1'b1, 8'hAA, 8'h01});
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10 held", {msg_valid, msg_vector, msg_dest}, {1'b1, 8'hAA, 8'h01});
        end
        take_msg();
        wait_msg(8, got);
        chk("R9 next line", {got, msg_vector, msg_dest}, {1'b1, 8'hCC, 8'h02});
        take_msg();
        quiet("R9 nothing left", 6);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule